// File: doc/BRIEF.md
# Multi-Source Interrupt Pending Aggregator

This block is the core of an interrupt controller for a set of level-sensitive sources. A source is enabled only when all of its mask enables are set. The block does not store the mask bits. Each source keeps a saturating count of its set enables and compares that count against a maximum fixed per source class. A source that is both asserted and enabled is pending. The block keeps a running total of pending sources and drives a single CPU interrupt request from that total through a two-state machine.

The CPU asks for a vector with a one-cycle strobe. One clock later the block answers with an acknowledge, a hit flag and the vector of the lowest-indexed pending source. An encoded 4-bit priority level input drives a chain of fifteen sources. A change of that level asserts exactly one chain entry and forces it enabled, and it deasserts the rest of the chain. Source 0 is reserved.

Interrupt request state machine:
- States: `IRQ_IDLE` (no source pending, request low) and `IRQ_ACTIVE` (at least one source pending, request high).
- Transitions: RAISE (`IRQ_IDLE` to `IRQ_ACTIVE`) when the next pending total leaves zero, and DROP (`IRQ_ACTIVE` to `IRQ_IDLE`) when it returns to zero. Otherwise the state holds.

Top module: `intc_agg_core`

## Requirements
- R1: Source n is enabled exactly when its enable count equals its maximum. The maximum is LOCAL_MAX (default 2) for local sources and CHAIN_MAX (default 1) for chain entries. A mask write with `msk_set`=1 adds one to the count of source `msk_idx`, and one with `msk_set`=0 subtracts one. A write that would exceed the maximum or go below zero leaves the count unchanged.
- R2: A source is pending exactly when it is asserted and enabled, two clock edges after the input that completes the condition.
- R3: The pending total rises by one for each source that becomes pending and falls by one for each source that stops being pending. `cpu_irq` stays high while any source remains pending.
- R4: `cpu_irq` is raised (RAISE) when the pending total leaves 0 and dropped (DROP) when the total returns to 0.
- R5: One cycle after `vec_req`, `vec_ack` is 1. When some source is pending, `vec_hit` is 1 and `vec_out` = VEC_BASE + i*VEC_STEP, where i is the lowest pending index (defaults 0x200 and 0x20). When no source is pending, `vec_hit` is 0 and `vec_out` is 0.
- R6: If `cpu_imask` is 4'hF at the request, the answer has `vec_hit`=0 and `vec_out`=0 even when sources are pending.
- R7: A local source is asserted while its `src_lvl` bit is high and deasserted while it is low. The `src_lvl` bits of chain entries have no effect.
- R8: A level L on `irl_lvl` selects chain entry IRL_BASE + (L xor 15), with IRL_BASE defaulting to 5. L=15 selects the first entry and L=1 selects the last. L=0 selects no entry.
- R9: The IRL level takes effect only in a cycle where `irl_lvl` differs from its previous value. In that cycle the selected entry is asserted and its count is set to its maximum, and every other chain entry is deasserted. A vector request in the same cycle sees the pending set from before the change.
- R10: Mask writes to source 0 are ignored, so source 0 never becomes pending.
- R11: While `rst_n` is low, all counts, assert flags, pending flags and the pending total are cleared, and `cpu_irq`, `vec_ack` and `vec_hit` are 0.
- R12: `vec_ack` is 0 in any cycle that does not follow a `vec_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_lvl | input | NSRC (20) | Level inputs of the local sources |
| msk_we | input | 1 | Mask enable write strobe |
| msk_idx | input | IW (5) | Source index of the mask write |
| msk_set | input | 1 | 1: one mask enable set, 0: one cleared |
| irl_lvl | input | 4 | Encoded priority level for the chain |
| vec_req | input | 1 | Vector request strobe |
| cpu_imask | input | 4 | CPU interrupt mask level |
| cpu_irq | output | 1 | CPU interrupt request |
| vec_ack | output | 1 | Vector answer valid |
| vec_hit | output | 1 | A pending source was found |
| vec_out | output | VEC_W (12) | Vector of the lowest pending source |

## Verification
The vector lookup and an IRL update can fall in the same cycle. In that cycle the lookup reads the registered pending flags while the update is rewriting the chain. The bench provokes this by changing `irl_lvl` on the same clock as `vec_req`, with one chain entry already pending. It judges the result through the scoreboard: the answer must still carry the vector of the old entry, and a request two cycles later must carry the vector of the new entry. A second overlap is a chain entry that stops being pending in the same cycle another starts. There the pending total must stay unchanged and `cpu_irq` must stay high.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int CHAIN_LEN = 15;
    localparam int IRL_W     = 4;

    typedef enum logic {
        IRQ_IDLE   = 1'b0,
        IRQ_ACTIVE = 1'b1
    } irq_state_t;
endpackage

// File: rtl/intc_src_slot.sv
module intc_src_slot #(
    parameter int CW       = 2,
    parameter int MAXV     = 2,
    parameter bit IS_CHAIN = 1'b0,
    parameter bit RESERVED = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    input  logic inc_i,
    input  logic dec_i,
    input  logic irl_upd_i,
    input  logic irl_sel_i,
    output logic asrt_o,
    output logic pend_o
);
    localparam logic [CW-1:0] TOP = CW'(MAXV);

    logic          asrt_q, asrt_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // assert state: local sources follow their level, chain entries follow IRL updates
    always_comb begin
        if (IS_CHAIN) begin
            asrt_d = irl_upd_i ? irl_sel_i : asrt_q;
        end else begin
            asrt_d = lvl_i;
        end
    end

    // saturating enable counter
    always_comb begin
        cnt_d = cnt_q;
        if (IS_CHAIN && irl_upd_i && irl_sel_i) begin
            cnt_d = TOP;
        end else if (!RESERVED) begin
            if (inc_i && (cnt_q != TOP)) begin
                cnt_d = cnt_q + 1'b1;
            end else if (dec_i && (cnt_q != '0)) begin
                cnt_d = cnt_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            asrt_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            asrt_q <= asrt_d;
            cnt_q  <= cnt_d;
        end
    end

    assign asrt_o = asrt_q;
    assign pend_o = asrt_q && (cnt_q == TOP);
endmodule

// File: rtl/intc_irl_decode.sv
module intc_irl_decode
    import intc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IRL_W-1:0]     irl_lvl_i,
    output logic                 upd_o,
    output logic [CHAIN_LEN-1:0] sel_o
);
    logic [IRL_W-1:0] prev_q;
    logic [IRL_W-1:0] slot;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= irl_lvl_i;
        end
    end

    assign slot  = irl_lvl_i ^ 4'hF;
    assign upd_o = (irl_lvl_i != prev_q);

    for (genvar k = 0; k < CHAIN_LEN; k++) begin : g_sel
        assign sel_o[k] = (slot == IRL_W'(k));
    end
endmodule

// File: rtl/intc_pend_tracker.sv
module intc_pend_tracker
    import intc_pkg::*;
#(
    parameter int NSRC = 20,
    parameter int PW   = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] pend_i,
    output logic [NSRC-1:0] pend_q_o,
    output logic [PW-1:0]   pend_cnt_o,
    output logic            irq_o
);
    logic [NSRC-1:0] pend_q;
    logic [PW-1:0]   cnt_q, cnt_d;
    irq_state_t      state_q, state_d;
    int              rises, falls;

    always_comb begin
        rises = 0;
        falls = 0;
        for (int i = 0; i < NSRC; i++) begin
            if (pend_i[i] && !pend_q[i]) rises = rises + 1;
            if (!pend_i[i] && pend_q[i]) falls = falls + 1;
        end
        cnt_d = PW'(int'(cnt_q) + rises - falls);
    end

    // next state: RAISE and DROP
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (cnt_d != '0) state_d = IRQ_ACTIVE;
            IRQ_ACTIVE: if (cnt_d == '0) state_d = IRQ_IDLE;
            default:    state_d = IRQ_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= IRQ_IDLE;
            cnt_q   <= '0;
            pend_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            pend_q  <= pend_i;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            IRQ_ACTIVE: irq_o = 1'b1;
            default:    irq_o = 1'b0;
        endcase
    end

    assign pend_q_o   = pend_q;
    assign pend_cnt_o = cnt_q;
endmodule

// File: rtl/intc_vec_finder.sv
module intc_vec_finder
    import intc_pkg::*;
#(
    parameter int NSRC     = 20,
    parameter int VEC_W    = 12,
    parameter int VEC_BASE = 'h200,
    parameter int VEC_STEP = 'h20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  pend_i,
    input  logic             req_i,
    input  logic [IRL_W-1:0] imask_i,
    output logic             ack_o,
    output logic             hit_o,
    output logic [VEC_W-1:0] vec_o
);
    logic             found;
    int               idx;
    logic [VEC_W-1:0] vcalc;

    // lowest-index pending source
    always_comb begin
        found = 1'b0;
        idx   = 0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                found = 1'b1;
                idx   = i;
            end
        end
        vcalc = VEC_W'(VEC_BASE + idx * VEC_STEP);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_o <= 1'b0;
            hit_o <= 1'b0;
            vec_o <= '0;
        end else begin
            ack_o <= req_i;
            if (req_i && found && (imask_i != 4'hF)) begin
                hit_o <= 1'b1;
                vec_o <= vcalc;
            end else begin
                hit_o <= 1'b0;
                vec_o <= '0;
            end
        end
    end
endmodule

// File: rtl/intc_agg_core.sv
module intc_agg_core
    import intc_pkg::*;
#(
    parameter int NSRC      = 20,
    parameter int IRL_BASE  = 5,
    parameter int LOCAL_MAX = 2,
    parameter int CHAIN_MAX = 1,
    parameter int VEC_W     = 12,
    parameter int VEC_BASE  = 'h200,
    parameter int VEC_STEP  = 'h20,
    localparam int IW       = $clog2(NSRC),
    localparam int PW       = $clog2(NSRC + 1),
    localparam int CW       = $clog2(((LOCAL_MAX > CHAIN_MAX) ? LOCAL_MAX : CHAIN_MAX) + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_lvl,
    input  logic             msk_we,
    input  logic [IW-1:0]    msk_idx,
    input  logic             msk_set,
    input  logic [IRL_W-1:0] irl_lvl,
    input  logic             vec_req,
    input  logic [IRL_W-1:0] cpu_imask,
    output logic             cpu_irq,
    output logic             vec_ack,
    output logic             vec_hit,
    output logic [VEC_W-1:0] vec_out
);
    logic                 irl_upd;
    logic [CHAIN_LEN-1:0] irl_sel;
    logic [NSRC-1:0]      asrt, pend_now, pend_q;
    logic [CHAIN_LEN-1:0] chain_asrt;
    logic [PW-1:0]        pend_cnt;

    intc_irl_decode u_irl (
        .clk       (clk),
        .rst_n     (rst_n),
        .irl_lvl_i (irl_lvl),
        .upd_o     (irl_upd),
        .sel_o     (irl_sel)
    );

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        localparam bit IN_CHAIN = (g >= IRL_BASE) && (g < IRL_BASE + CHAIN_LEN);
        logic inc, dec, sel;
        assign inc = msk_we &&  msk_set && (msk_idx == IW'(g));
        assign dec = msk_we && !msk_set && (msk_idx == IW'(g));
        if (IN_CHAIN) begin : g_chain
            assign sel = irl_sel[g - IRL_BASE];
            assign chain_asrt[g - IRL_BASE] = asrt[g];
        end else begin : g_local
            assign sel = 1'b0;
        end
        intc_src_slot #(
            .CW       (CW),
            .MAXV     (IN_CHAIN ? CHAIN_MAX : LOCAL_MAX),
            .IS_CHAIN (IN_CHAIN),
            .RESERVED (g == 0)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .lvl_i     (src_lvl[g]),
            .inc_i     (inc),
            .dec_i     (dec),
            .irl_upd_i (irl_upd),
            .irl_sel_i (sel),
            .asrt_o    (asrt[g]),
            .pend_o    (pend_now[g])
        );
    end

    intc_pend_tracker #(.NSRC(NSRC), .PW(PW)) u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend_i     (pend_now),
        .pend_q_o   (pend_q),
        .pend_cnt_o (pend_cnt),
        .irq_o      (cpu_irq)
    );

    intc_vec_finder #(
        .NSRC     (NSRC),
        .VEC_W    (VEC_W),
        .VEC_BASE (VEC_BASE),
        .VEC_STEP (VEC_STEP)
    ) u_vec (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend_i  (pend_q),
        .req_i   (vec_req),
        .imask_i (cpu_imask),
        .ack_o   (vec_ack),
        .hit_o   (vec_hit),
        .vec_o   (vec_out)
    );
endmodule

// File: rtl/intc_agg_chk.sv
module intc_agg_chk
    import intc_pkg::*;
#(
    parameter int NSRC = 20,
    parameter int PW   = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NSRC-1:0]      pend_q,
    input logic [PW-1:0]        pend_cnt,
    input logic [CHAIN_LEN-1:0] chain_asrt,
    input logic                 cpu_irq,
    input logic                 vec_req,
    input logic [IRL_W-1:0]     cpu_imask,
    input logic                 vec_ack,
    input logic                 vec_hit
);
    p_total_matches_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pend_cnt == PW'($countones(pend_q)));

    p_irq_tracks_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq == (pend_q != '0));

    p_raise_from_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_irq) |-> $past(pend_cnt) == '0);

    p_ack_after_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req |=> vec_ack);

    p_no_ack_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_req |=> !vec_ack);

    p_masked_no_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_req && cpu_imask == 4'hF) |=> !vec_hit);

    p_hit_needs_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_req && pend_q == '0) |=> !vec_hit);

    p_chain_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chain_asrt));

    p_reserved_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_q[0]);
endmodule

bind intc_agg_core intc_agg_chk #(.NSRC(NSRC), .PW(PW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pend_q     (pend_q),
    .pend_cnt   (pend_cnt),
    .chain_asrt (chain_asrt),
    .cpu_irq    (cpu_irq),
    .vec_req    (vec_req),
    .cpu_imask  (cpu_imask),
    .vec_ack    (vec_ack),
    .vec_hit    (vec_hit)
);

// File: tb/sim_intc_agg_core.sv
`timescale 1ns/1ps
module sim_intc_agg_core;
    localparam int NSRC = 20;
    localparam int IW   = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src_lvl = '0;
    logic            msk_we = 1'b0;
    logic [IW-1:0]   msk_idx = '0;
    logic            msk_set = 1'b0;
    logic [3:0]      irl_lvl = '0;
    logic            vec_req = 1'b0;
    logic [3:0]      cpu_imask = '0;
    logic            cpu_irq, vec_ack, vec_hit;
    logic [11:0]     vec_out;

    int checks = 0;
    int fails  = 0;
    logic [12:0] exp_q [$];   // {hit, vector}
    string       tag_q [$];

    always #4 clk = ~clk;   // 125 MHz

    intc_agg_core u0 (
        .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .msk_we(msk_we),
        .msk_idx(msk_idx), .msk_set(msk_set), .irl_lvl(irl_lvl),
        .vec_req(vec_req), .cpu_imask(cpu_imask), .cpu_irq(cpu_irq),
        .vec_ack(vec_ack), .vec_hit(vec_hit), .vec_out(vec_out)
    );

    function automatic logic [11:0] vec_of(int i);
        return 12'(32'h200 + i * 32'h20);
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic chk(logic ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic chk_irq(logic exp, string tag);
        chk(cpu_irq == exp, tag, int'(cpu_irq), int'(exp));
    endtask

    task automatic mask(int idx, logic setv);
        @(negedge clk);
        msk_we = 1'b1; msk_idx = IW'(idx); msk_set = setv;
        @(negedge clk);
        msk_we = 1'b0;
    endtask

    // driver: request a vector and push the expected answer
    task automatic vreq(logic [3:0] im, logic hit, logic [11:0] v, string tag);
        @(negedge clk);
        vec_req = 1'b1; cpu_imask = im;
        exp_q.push_back({hit, v}); tag_q.push_back(tag);
        @(negedge clk);
        vec_req = 1'b0; cpu_imask = 4'h0;
        @(negedge clk);
    endtask

    // monitor: compare each answer against the scoreboard
    always @(negedge clk) begin
        if (rst_n && vec_ack) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R12 unexpected ack", 1, 0);
            end else begin
                logic [12:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk({vec_hit, vec_out} == e, t, int'({vec_hit, vec_out}), int'(e));
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(cpu_irq == 1'b0 && vec_ack == 1'b0 && vec_hit == 1'b0, "R11 reset outputs",
            int'({cpu_irq, vec_ack, vec_hit}), 0);
        rst_n = 1'b1;
        settle();
        chk(vec_ack == 1'b0, "R12 no ack without request", int'(vec_ack), 0);

        // local source 1 needs two mask enables
        src_lvl[1] = 1'b1; settle();
        chk_irq(1'b0, "R1 count 0 not enabled");
        mask(1, 1'b1); settle();
        chk_irq(1'b0, "R1 one of two enables");
        mask(1, 1'b1); settle();
        chk_irq(1'b1, "R2 asserted and enabled");
        vreq(4'h0, 1'b1, vec_of(1), "R5 vector of source 1");
        mask(1, 1'b1); mask(1, 1'b0); settle();
        chk_irq(1'b0, "R1 saturated count then one clear");
        mask(1, 1'b1); settle();
        chk_irq(1'b1, "R1 re-enabled");
        src_lvl[1] = 1'b0; settle();
        chk_irq(1'b0, "R7 level low deasserts");
        vreq(4'h0, 1'b0, 12'h000, "R5 nothing pending");

        // reserved source 0
        src_lvl[0] = 1'b1;
        mask(0, 1'b1); mask(0, 1'b1); settle();
        chk_irq(1'b0, "R10 source 0 mask writes ignored");
        src_lvl[0] = 1'b0;

        // chain entry level pin ignored
        mask(5, 1'b1); src_lvl[5] = 1'b1; settle();
        chk_irq(1'b0, "R7 chain level pin ignored");
        src_lvl[5] = 1'b0;

        // IRL 15 selects entry 5
        irl_lvl = 4'd15; settle();
        chk_irq(1'b1, "R8 level 15 raises entry 5");
        vreq(4'h0, 1'b1, vec_of(5), "R8 vector of entry 5");

        // local source 2 wins lowest index
        mask(2, 1'b1); mask(2, 1'b1); src_lvl[2] = 1'b1; settle();
        vreq(4'h0, 1'b1, vec_of(2), "R5 lowest index wins");
        vreq(4'hF, 1'b0, 12'h000, "R6 mask level F");
        src_lvl[2] = 1'b0; settle();
        chk_irq(1'b1, "R3 request held by remaining source");

        // same-cycle IRL change and vector request
        @(negedge clk);
        irl_lvl = 4'd14; vec_req = 1'b1; cpu_imask = 4'h0;
        exp_q.push_back({1'b1, vec_of(5)}); tag_q.push_back("R9 same-cycle sees old set");
        @(negedge clk);
        vec_req = 1'b0;
        settle();
        chk_irq(1'b1, "R3 hand-over keeps request");
        vreq(4'h0, 1'b1, vec_of(6), "R9 old entry deasserted");

        // chain mask clear, update only on change
        mask(6, 1'b0); settle();
        chk_irq(1'b0, "R1 chain entry disabled");
        settle();
        chk_irq(1'b0, "R9 unchanged level not reapplied");
        irl_lvl = 4'd13; settle();
        chk_irq(1'b1, "R9 new entry forced enabled");
        vreq(4'h0, 1'b1, vec_of(7), "R8 vector of entry 7");

        irl_lvl = 4'd0; settle();
        chk_irq(1'b0, "R4 level 0 drops request");
        vreq(4'h0, 1'b0, 12'h000, "R8 level 0 selects none");

        irl_lvl = 4'd1; settle();
        chk_irq(1'b1, "R8 level 1 raises last entry");
        vreq(4'h0, 1'b1, vec_of(19), "R8 vector of entry 19");

        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk(cpu_irq == 1'b0 && vec_ack == 1'b0, "R11 reset mid-run",
            int'({cpu_irq, vec_ack}), 0);
        irl_lvl = 4'd0; rst_n = 1'b1;
        settle();

        chk(exp_q.size() == 0, "R5 all answers seen", exp_q.size(), 0);
        summary();
    end
endmodule